// File: doc/BRIEF.md
# Byte-Splittable General Register File

This block is the programmer-visible register store of a 16-bit processor datapath. It keeps four general registers, four pointer/index registers and four segment registers. The general registers can be addressed either as whole 16-bit words or as their low or high bytes on their own, so byte-sized instructions can update half a register without a read-modify-write. The instruction pointer, the flags and instruction decoding sit elsewhere.

There is one write port and two read ports. Each port takes a 4-bit selector and a byte/word flag. Read port A feeds the ALU and refuses segment selectors, because segment registers may not be arithmetic operands. Read port B serves address generation and can read every register. The code segment register ignores the write port completely and is loaded only through a separate far-transfer path, which the sequencer drives on far jumps, far calls and far returns.

Selector layout: bit 3 clear selects the general/pointer space. In that space, word mode 0..7 means AX, CX, DX, BX, SP, BP, SI, DI. Byte mode 0..3 means AL, CL, DL, BL and 4..7 means AH, CH, DH, BH. Bit 3 set selects the segment space, where bits 1:0 pick extra (0), code (1), stack (2) or data (3), and bit 2 must be zero.

Top module: `gp_regfile`

## Requirements
- R1: While rst_n is low, and after it, every register reads as 0x0000 until it is written, the code segment included.
- R2: A word write with selector bit 3 clear and value 0..7 stores all 16 bits into AX, CX, DX, BX, SP, BP, SI, DI respectively. The new value is readable on both read ports from the clock edge that follows the write cycle, and not in the write cycle itself.
- R3: A byte write with selector 0..3 stores wr_data[7:0] into bits 7:0 of AX, CX, DX, BX. With selector 4..7 it stores wr_data[7:0] into bits 15:8 of the same four registers. The other half of the register keeps its value.
- R4: A byte read returns the selected half (0..3 low halves, 4..7 high halves of AX, CX, DX, BX) in bits 7:0, with bits 15:8 equal to zero.
- R5: A word write with selector 4'b1000, 4'b1010 or 4'b1011 stores into the extra, stack or data segment register, which port B then reads with the same selector.
- R6: A write with selector 4'b1001 (code segment) leaves the code segment register unchanged.
- R7: When far_load is high at a clock edge, the code segment takes far_cs at that edge. This works even if an ordinary write to another register happens in the same cycle, and that write also takes effect.
- R8: When port A's selector has bit 3 set, rda_reject is 1 and rda_data is 0x0000. Otherwise rda_reject is 0 and rda_data follows the same decoding as port B.
- R9: Selectors with bit 3 set combined with byte mode or with bit 2 set are invalid. Writes using them change no register, and port B reads them as 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 4 | Write register selector |
| wr_byte | input | 1 | 1 = byte write, 0 = word write |
| wr_data | input | 16 | Write value (byte writes use bits 7:0) |
| far_load | input | 1 | Load code segment on a far transfer |
| far_cs | input | 16 | New code segment value |
| rda_sel | input | 4 | Port A (ALU) selector |
| rda_byte | input | 1 | Port A byte mode |
| rda_data | output | 16 | Port A read value |
| rda_reject | output | 1 | Port A was given a segment selector |
| rdb_sel | input | 4 | Port B selector |
| rdb_byte | input | 1 | Port B byte mode |
| rdb_data | output | 16 | Port B read value |

## Verification
The in-design assertions watch, on every cycle, that the code segment moves only when far_load is high and then takes the loaded value. They also check that a byte write leaves the partner half of its register untouched, that byte reads carry zero upper bits, and that a rejected port A read returns zero. The bench scenarios are what show the encodings themselves: which selector reaches which register and half, that an ordinary write to the code segment is dropped, that invalid segment selectors write nothing, and that reset clears everything, including a reset in the middle of a run.

// File: rtl/gp_regfile.sv
module gp_regfile (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [3:0]  wr_sel,
  input  logic        wr_byte,
  input  logic [15:0] wr_data,
  input  logic        far_load,
  input  logic [15:0] far_cs,
  input  logic [3:0]  rda_sel,
  input  logic        rda_byte,
  output logic [15:0] rda_data,
  output logic        rda_reject,
  input  logic [3:0]  rdb_sel,
  input  logic        rdb_byte,
  output logic [15:0] rdb_data
);

  localparam logic [1:0] CS_IDX = 2'd1;

  logic [7:0]  lo_q  [4];
  logic [7:0]  hi_q  [4];
  logic [15:0] ptr_q [4];
  logic [15:0] seg_q [4];

  wire w_seg   = wr_sel[3];
  wire w_bad   = w_seg && (wr_byte || wr_sel[2] || wr_sel[1:0] == CS_IDX);
  wire w_go    = wr_en && !w_bad;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin
        lo_q[i]  <= '0;
        hi_q[i]  <= '0;
        ptr_q[i] <= '0;
        seg_q[i] <= '0;
      end
    end else begin
      if (w_go) begin
        if (w_seg)
          seg_q[wr_sel[1:0]] <= wr_data;
        else if (wr_byte) begin
          if (wr_sel[2]) hi_q[wr_sel[1:0]] <= wr_data[7:0];
          else           lo_q[wr_sel[1:0]] <= wr_data[7:0];
        end else if (wr_sel[2])
          ptr_q[wr_sel[1:0]] <= wr_data;
        else begin
          lo_q[wr_sel[1:0]] <= wr_data[7:0];
          hi_q[wr_sel[1:0]] <= wr_data[15:8];
        end
      end
      if (far_load) seg_q[CS_IDX] <= far_cs;
    end
  end

  function automatic logic [15:0] fetch(input logic [3:0] s, input logic b);
    logic [15:0] v;
    if (s[3])
      v = (b || s[2]) ? 16'h0000 : seg_q[s[1:0]];
    else if (b)
      v = {8'h00, s[2] ? hi_q[s[1:0]] : lo_q[s[1:0]]};
    else if (s[2])
      v = ptr_q[s[1:0]];
    else
      v = {hi_q[s[1:0]], lo_q[s[1:0]]};
    return v;
  endfunction

  assign rda_reject = rda_sel[3];
  assign rda_data   = rda_sel[3] ? 16'h0000 : fetch(rda_sel, rda_byte);
  assign rdb_data   = fetch(rdb_sel, rdb_byte);

  assert_cs_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !far_load |=> $stable(seg_q[CS_IDX]));

  assert_cs_far_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    far_load |=> seg_q[CS_IDX] == $past(far_cs));

  assert_byte_keeps_hi_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_byte && !wr_sel[3] && !wr_sel[2])
      |=> hi_q[$past(wr_sel[1:0])] == $past(hi_q[wr_sel[1:0]]));

  assert_byte_keeps_lo_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_byte && !wr_sel[3] && wr_sel[2])
      |=> lo_q[$past(wr_sel[1:0])] == $past(lo_q[wr_sel[1:0]]));

  assert_byte_zero_ext_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rdb_byte && !rdb_sel[3]) |-> rdb_data[15:8] == 8'h00);

  assert_alu_reject_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rda_reject |-> rda_data == 16'h0000);

endmodule

// File: tb/sim_gp_regfile.sv
`timescale 1ns/1ps
module sim_gp_regfile;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic [3:0]  wr_sel = 0;
  logic        wr_byte = 0;
  logic [15:0] wr_data = 0;
  logic        far_load = 0;
  logic [15:0] far_cs = 0;
  logic [3:0]  rda_sel = 0;
  logic        rda_byte = 0;
  logic [15:0] rda_data;
  logic        rda_reject;
  logic [3:0]  rdb_sel = 0;
  logic        rdb_byte = 0;
  logic [15:0] rdb_data;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  gp_regfile u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_byte(wr_byte),
    .wr_data(wr_data), .far_load(far_load), .far_cs(far_cs),
    .rda_sel(rda_sel), .rda_byte(rda_byte), .rda_data(rda_data), .rda_reject(rda_reject),
    .rdb_sel(rdb_sel), .rdb_byte(rdb_byte), .rdb_data(rdb_data)
  );

  // {req, we, wsel, wbyte, wdata, rsel, rbyte, expected}
  localparam int NV = 14;
  localparam logic [46:0] VEC [NV] = '{
    {4'd2, 1'b1, 4'h0, 1'b0, 16'h1234, 4'h0, 1'b0, 16'h1234}, // R2 AX word
    {4'd3, 1'b1, 4'h4, 1'b1, 16'h99AB, 4'h0, 1'b0, 16'hAB34}, // R3 AH byte
    {4'd3, 1'b1, 4'h0, 1'b1, 16'h77CD, 4'h0, 1'b0, 16'hABCD}, // R3 AL byte
    {4'd4, 1'b0, 4'h0, 1'b0, 16'h0000, 4'h4, 1'b1, 16'h00AB}, // R4 read AH
    {4'd4, 1'b1, 4'h3, 1'b0, 16'hBEEF, 4'h7, 1'b1, 16'h00BE}, // R4 BX then BH
    {4'd3, 1'b1, 4'h1, 1'b1, 16'hFF55, 4'h1, 1'b0, 16'h0055}, // R3 CL
    {4'd3, 1'b1, 4'h6, 1'b1, 16'h0077, 4'h2, 1'b0, 16'h7700}, // R3 DH
    {4'd2, 1'b1, 4'h4, 1'b0, 16'hFFFE, 4'h4, 1'b0, 16'hFFFE}, // R2 SP
    {4'd2, 1'b1, 4'h7, 1'b0, 16'h0102, 4'h7, 1'b0, 16'h0102}, // R2 DI
    {4'd5, 1'b1, 4'hB, 1'b0, 16'h2000, 4'hB, 1'b0, 16'h2000}, // R5 data seg
    {4'd5, 1'b1, 4'hA, 1'b0, 16'h3000, 4'hA, 1'b0, 16'h3000}, // R5 stack seg
    {4'd6, 1'b1, 4'h9, 1'b0, 16'hFFFF, 4'h9, 1'b0, 16'h0000}, // R6 code seg write dropped
    {4'd9, 1'b1, 4'h8, 1'b1, 16'h0012, 4'h8, 1'b0, 16'h0000}, // R9 seg byte write
    {4'd9, 1'b1, 4'hC, 1'b0, 16'h9999, 4'hC, 1'b0, 16'h0000}  // R9 seg bit2 set
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [3:0] s, input logic b, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1; wr_sel = s; wr_byte = b; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic read_b(input logic [3:0] s, input logic b);
    rdb_sel = s; rdb_byte = b;
    #0.5;
  endtask

  task automatic all_zero(input string tag);
    for (int i = 0; i < 8; i++) begin
      read_b(i[3:0], 1'b0);
      check(tag, rdb_data, 16'h0000);
    end
    for (int i = 0; i < 4; i++) begin
      read_b({2'b10, i[1:0]}, 1'b0);
      check(tag, rdb_data, 16'h0000);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    all_zero("R1 during reset");
    rst_n = 1;
    @(negedge clk);
    all_zero("R1 after reset");

    for (int v = 0; v < NV; v++) begin
      logic [46:0] e;
      e = VEC[v];
      if (e[42]) do_write(e[41:38], e[37], e[36:21]);
      else @(negedge clk);
      read_b(e[20:17], e[16]);
      check($sformatf("R%0d vec%0d", e[46:43], v), rdb_data, e[15:0]);
    end

    // R2: a write is not visible in its own cycle
    @(negedge clk);
    wr_en = 1; wr_sel = 4'h5; wr_byte = 0; wr_data = 16'hCAFE;
    read_b(4'h5, 1'b0);
    check("R2 same cycle", rdb_data, 16'h0000);
    @(posedge clk); @(negedge clk); wr_en = 0;
    read_b(4'h5, 1'b0);
    check("R2 next cycle", rdb_data, 16'hCAFE);

    // R8: port A
    rda_sel = 4'hB; rda_byte = 0; #0.5;
    check("R8 seg reject data", rda_data, 16'h0000);
    check("R8 seg reject flag", {15'd0, rda_reject}, 16'h0001);
    rda_sel = 4'h0; #0.5;
    check("R8 AX on port A", rda_data, 16'hABCD);
    check("R8 no reject", {15'd0, rda_reject}, 16'h0000);
    rda_sel = 4'h7; rda_byte = 1; #0.5;
    check("R8 BH on port A", rda_data, 16'h00BE);

    // R7: far load alongside an ordinary write
    @(negedge clk);
    far_load = 1; far_cs = 16'hF000;
    wr_en = 1; wr_sel = 4'h6; wr_byte = 0; wr_data = 16'h4321;
    @(posedge clk); @(negedge clk);
    far_load = 0; far_cs = 16'h1111; wr_en = 0;
    read_b(4'h9, 1'b0);
    check("R7 code seg loaded", rdb_data, 16'hF000);
    read_b(4'h6, 1'b0);
    check("R7 concurrent write", rdb_data, 16'h4321);
    @(negedge clk);
    read_b(4'h9, 1'b0);
    check("R6 code seg holds", rdb_data, 16'hF000);

    // R9: the invalid writes left the extra segment alone
    read_b(4'h8, 1'b0);
    check("R9 extra seg untouched", rdb_data, 16'h0000);

    // R1: reset mid-run
    @(negedge clk); rst_n = 0;
    @(posedge clk); @(negedge clk);
    rst_n = 1;
    all_zero("R1 mid-run reset");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule